// File: doc/BRIEF.md
# Function-Code-Tagged Address Translation Cache

This block is a small fully associative cache of recent address translations. Each entry pairs a logical page number with a physical frame number. It is tagged with the 3-bit access function code of the cycle that created it, so one logical page seen from user, supervisor, program or data space can hold separate translations. A table-walking engine fills the cache through an insert port. It passes the logical and physical addresses, the function code, the access direction and the fault flags the walk found. The processor side sends a logical address, function code and direction to the lookup port. One cycle later it receives the translated address with status flags, or a miss.

The page size comes from a 4-bit configuration field holding the number of offset bits. Offset bits pass straight from the logical to the physical address. A write that hits an entry not yet marked modified is turned into a miss and the entry is dropped. The walker can then mark the descriptor and refill the entry with the modified flag set. Three flush commands remove entries: all of them, those whose masked function code matches a requested code, or those that also match a given page.

Top module: `fc_xlate_cache`

## Requirements
- R1: After reset every entry is invalid and `rsp_valid` is 0, so the first lookup misses.
- R2: A lookup accepted in cycle n produces `rsp_valid`=1 in cycle n+1. On a hit, `rsp_addr` is the stored frame in bits 31:8 (bits below the page size zero) ORed with the lookup address bits below the page size.
- R3: With page-size field `ps` in 8..15, address bits `ps-1:0` form the offset and bits 31:`ps` form the page number. Values below 8 act as 8. Two addresses that differ only in offset bits hit the same entry.
- R4: A lookup hits only an entry whose function code equals the lookup code exactly.
- R5: On insert, the stored bus-error flag is the OR of `ins_berr`, `ins_inval` and `ins_supv`. Write-protect is copied from `ins_wprot`. Modified is set when `ins_read`=0 and `ins_wprot`=0. A hit reports `rsp_wprot` and `rsp_mod` as stored. A stored bus error sets both `rsp_berr` and `rsp_inval`.
- R6: A write lookup (`lk_read`=0) that matches an entry whose modified flag is clear reports a miss and invalidates that entry.
- R7: A miss reports `rsp_hit`=0, `rsp_inval`=1, `rsp_berr`=`rsp_wprot`=`rsp_mod`=0 and `rsp_addr`=0.
- R8: An insert whose function code and page match a valid entry overwrites that entry in place and allocates no new one.
- R9: Otherwise an insert takes the lowest-numbered invalid entry. If every entry is valid, it replaces the entry named by a round-robin pointer. The pointer starts at 0, advances only on such a replacement, and wraps from 15 to 0.
- R10: Flush with `fl_mode`=0 invalidates every entry and returns the round-robin pointer to 0.
- R11: Flush with `fl_mode`=1 invalidates valid entries whose function code ANDed with `fl_mask` equals `fl_fc` ANDed with `fl_mask`.
- R12: Flush with `fl_mode`=2 applies the R11 condition and also requires the entry's page to equal the page of `fl_addr`. `fl_mode`=3 changes nothing.
- R13: Only one operation is accepted per cycle, in the priority flush, insert, lookup. A lookup held off by a flush or an insert gets no response (`rsp_valid`=0 the next cycle) and changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_page_bits | input | 4 | Number of page offset bits (8..15) |
| ins_valid | input | 1 | Insert request |
| ins_laddr | input | 32 | Logical address to insert |
| ins_paddr | input | 32 | Physical address to insert |
| ins_fc | input | 3 | Function code of inserted entry |
| ins_read | input | 1 | 1 = read access, 0 = write |
| ins_berr | input | 1 | Walk reported bus error |
| ins_inval | input | 1 | Walk reported invalid descriptor |
| ins_supv | input | 1 | Walk reported supervisor-only violation |
| ins_wprot | input | 1 | Walk reported write protection |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Logical address to translate |
| lk_fc | input | 3 | Function code of lookup |
| lk_read | input | 1 | 1 = read access, 0 = write |
| fl_valid | input | 1 | Flush request |
| fl_mode | input | 2 | 0 all, 1 by code, 2 by code and page, 3 none |
| fl_fc | input | 3 | Function code to flush |
| fl_mask | input | 3 | Mask applied to function codes |
| fl_addr | input | 32 | Address whose page is flushed in mode 2 |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Translation found |
| rsp_addr | output | 32 | Translated address |
| rsp_berr | output | 1 | Entry carries bus error |
| rsp_inval | output | 1 | Miss or bus error |
| rsp_wprot | output | 1 | Entry write-protected |
| rsp_mod | output | 1 | Entry modified |

## Verification
An insert and a lookup can be presented in the same cycle. The bench drives both on the same clock edge and expects no response the following cycle. It then repeats the lookup alone and expects a hit on the address that was inserted, which proves the insert took effect while the lookup was dropped. The same pairing is repeated with a flush against an insert and against a lookup. Each time the bench confirms that the lower-priority operation left the outputs and the stored entries untouched.

// File: rtl/fcx_pkg.sv
package fcx_pkg;
  parameter int FCX_AW = 32;
  parameter int FCX_FCW = 3;
  parameter int FCX_PSW = 4;
  localparam int FCX_KW = FCX_AW - 8;

  typedef struct packed {
    logic               vld;
    logic [FCX_FCW-1:0] fc;
    logic [FCX_KW-1:0]  page;
  } fcx_tag_t;

  typedef struct packed {
    logic              berr;
    logic              wp;
    logic              mod;
    logic [FCX_KW-1:0] frame;
  } fcx_data_t;

  typedef enum logic [1:0] {
    FL_ALL       = 2'd0,
    FL_CODE      = 2'd1,
    FL_CODE_ADDR = 2'd2,
    FL_NONE      = 2'd3
  } fcx_flush_e;

  // page number scaled down by 8, with bits below the page size cleared
  function automatic logic [FCX_KW-1:0] fcx_key(input logic [FCX_AW-1:0] a,
                                                input logic [FCX_PSW-1:0] ps);
    logic [FCX_KW-1:0] m;
    m = '1;
    if (ps > 4'd8) m = m << (ps - 4'd8);
    return FCX_KW'(a >> 8) & m;
  endfunction

  // offset bits that pass through untranslated
  function automatic logic [FCX_AW-1:0] fcx_low(input logic [FCX_PSW-1:0] ps);
    logic [FCX_AW-1:0] m;
    if (ps <= 4'd8) m = FCX_AW'(8'hff);
    else            m = ~({FCX_AW{1'b1}} << ps);
    return m;
  endfunction
endpackage

// File: rtl/fcx_match.sv
module fcx_match
  import fcx_pkg::*;
#(
  parameter int N = 16
) (
  input  fcx_tag_t [N-1:0]     tags,
  input  logic [FCX_KW-1:0]    key,
  input  logic [FCX_FCW-1:0]   fc,
  input  logic [FCX_FCW-1:0]   mask,
  input  logic                 use_key,
  output logic [N-1:0]         hit
);
  logic [FCX_FCW-1:0] fc_m;
  assign fc_m = fc & mask;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    logic code_ok;
    logic page_ok;
    assign code_ok = ((tags[g].fc & mask) == fc_m);
    assign page_ok = !use_key || (tags[g].page == key);
    assign hit[g]  = tags[g].vld && code_ok && page_ok;
  end
endmodule

// File: rtl/fcx_prio.sv
module fcx_prio #(
  parameter int N = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/fcx_store.sv
module fcx_store
  import fcx_pkg::*;
#(
  parameter int N = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear_all,
  input  logic [N-1:0]        clr_vec,
  input  logic                wr_en,
  input  logic [IW-1:0]       wr_idx,
  input  fcx_tag_t            wr_tag,
  input  fcx_data_t           wr_data,
  input  logic                rr_adv,
  output fcx_tag_t [N-1:0]    tags,
  output fcx_data_t [N-1:0]   datas,
  output logic [IW-1:0]       rr
);
  fcx_tag_t [N-1:0] tags_d;
  logic [IW-1:0]    rr_d;

  always_comb begin
    tags_d = tags;
    for (int i = 0; i < N; i++) begin
      if (clear_all || clr_vec[i]) tags_d[i] = '0;
    end
    if (wr_en) tags_d[wr_idx] = wr_tag;
  end

  always_comb begin
    rr_d = rr;
    if (clear_all)   rr_d = '0;
    else if (rr_adv) rr_d = (rr == IW'(N - 1)) ? '0 : rr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tags <= '0;
      rr   <= '0;
    end else begin
      tags <= tags_d;
      rr   <= rr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) datas[wr_idx] <= wr_data;
  end
endmodule

// File: rtl/fc_xlate_cache.sv
module fc_xlate_cache
  import fcx_pkg::*;
#(
  parameter int N_ENT = 16,
  localparam int IW = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         cfg_page_bits,
  input  logic               ins_valid,
  input  logic [31:0]        ins_laddr,
  input  logic [31:0]        ins_paddr,
  input  logic [2:0]         ins_fc,
  input  logic               ins_read,
  input  logic               ins_berr,
  input  logic               ins_inval,
  input  logic               ins_supv,
  input  logic               ins_wprot,
  input  logic               lk_valid,
  input  logic [31:0]        lk_addr,
  input  logic [2:0]         lk_fc,
  input  logic               lk_read,
  input  logic               fl_valid,
  input  logic [1:0]         fl_mode,
  input  logic [2:0]         fl_fc,
  input  logic [2:0]         fl_mask,
  input  logic [31:0]        fl_addr,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [31:0]        rsp_addr,
  output logic               rsp_berr,
  output logic               rsp_inval,
  output logic               rsp_wprot,
  output logic               rsp_mod
);
  // operation arbitration: flush, then insert, then lookup
  logic do_fl, do_ins, do_lk;
  assign do_fl  = fl_valid;
  assign do_ins = ins_valid && !fl_valid;
  assign do_lk  = lk_valid && !ins_valid && !fl_valid;

  logic [FCX_KW-1:0] lk_key, ins_key, ins_frame, fl_key;
  assign lk_key    = fcx_key(lk_addr, cfg_page_bits);
  assign ins_key   = fcx_key(ins_laddr, cfg_page_bits);
  assign ins_frame = fcx_key(ins_paddr, cfg_page_bits);
  assign fl_key    = fcx_key(fl_addr, cfg_page_bits);

  fcx_tag_t  [N_ENT-1:0] tags;
  fcx_data_t [N_ENT-1:0] datas;
  logic [IW-1:0]         rr;

  logic [N_ENT-1:0] lk_hv, ins_hv, fl_hv, free_v;
  for (genvar g = 0; g < N_ENT; g++) begin : g_free
    assign free_v[g] = !tags[g].vld;
  end

  fcx_match #(.N(N_ENT)) u_lk_m (
    .tags(tags), .key(lk_key), .fc(lk_fc), .mask(3'b111),
    .use_key(1'b1), .hit(lk_hv));
  fcx_match #(.N(N_ENT)) u_ins_m (
    .tags(tags), .key(ins_key), .fc(ins_fc), .mask(3'b111),
    .use_key(1'b1), .hit(ins_hv));
  fcx_match #(.N(N_ENT)) u_fl_m (
    .tags(tags), .key(fl_key), .fc(fl_fc), .mask(fl_mask),
    .use_key(fl_mode == FL_CODE_ADDR), .hit(fl_hv));

  logic          lk_any, ins_any, free_any;
  logic [IW-1:0] lk_idx, ins_idx, free_idx;
  fcx_prio #(.N(N_ENT)) u_lk_p   (.req(lk_hv),  .any(lk_any),   .idx(lk_idx));
  fcx_prio #(.N(N_ENT)) u_ins_p  (.req(ins_hv), .any(ins_any),  .idx(ins_idx));
  fcx_prio #(.N(N_ENT)) u_free_p (.req(free_v), .any(free_any), .idx(free_idx));

  // lookup evaluation
  fcx_data_t lk_ent;
  logic      lk_wr_unmod, lk_good;
  assign lk_ent      = datas[lk_idx];
  assign lk_wr_unmod = lk_any && !lk_read && !lk_ent.mod;
  assign lk_good     = lk_any && !lk_wr_unmod;

  // entry invalidation and clearing
  logic             clear_all;
  logic [N_ENT-1:0] clr_vec;
  always_comb begin
    clr_vec = '0;
    if (do_fl && (fl_mode == FL_CODE || fl_mode == FL_CODE_ADDR))
      clr_vec = fl_hv;
    else if (do_lk && lk_wr_unmod)
      clr_vec[lk_idx] = 1'b1;
  end
  assign clear_all = do_fl && (fl_mode == FL_ALL);

  // insert placement
  logic          rr_adv;
  logic [IW-1:0] wr_idx;
  fcx_tag_t      wr_tag;
  fcx_data_t     wr_data;
  always_comb begin
    if (ins_any)       wr_idx = ins_idx;
    else if (free_any) wr_idx = free_idx;
    else               wr_idx = rr;
  end
  assign rr_adv       = do_ins && !ins_any && !free_any;
  assign wr_tag.vld   = 1'b1;
  assign wr_tag.fc    = ins_fc;
  assign wr_tag.page  = ins_key;
  assign wr_data.berr = ins_berr || ins_inval || ins_supv;
  assign wr_data.wp   = ins_wprot;
  assign wr_data.mod  = !ins_read && !ins_wprot;
  assign wr_data.frame = ins_frame;

  fcx_store #(.N(N_ENT)) u_store (
    .clk(clk), .rst_n(rst_n), .clear_all(clear_all), .clr_vec(clr_vec),
    .wr_en(do_ins), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data),
    .rr_adv(rr_adv), .tags(tags), .datas(datas), .rr(rr));

  // response next state
  logic        hit_d, berr_d, inval_d, wp_d, mod_d;
  logic [31:0] addr_d;
  always_comb begin
    hit_d   = lk_good;
    berr_d  = lk_good && lk_ent.berr;
    inval_d = !lk_good || lk_ent.berr;
    wp_d    = lk_good && lk_ent.wp;
    mod_d   = lk_good && lk_ent.mod;
    addr_d  = '0;
    if (lk_good)
      addr_d = {lk_ent.frame, 8'h00} | (lk_addr & fcx_low(cfg_page_bits));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_addr  <= '0;
      rsp_berr  <= 1'b0;
      rsp_inval <= 1'b0;
      rsp_wprot <= 1'b0;
      rsp_mod   <= 1'b0;
    end else begin
      rsp_valid <= do_lk;
      if (do_lk) begin
        rsp_hit   <= hit_d;
        rsp_addr  <= addr_d;
        rsp_berr  <= berr_d;
        rsp_inval <= inval_d;
        rsp_wprot <= wp_d;
        rsp_mod   <= mod_d;
      end
    end
  end
endmodule

// File: rtl/fcx_chk.sv
module fcx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ins_valid,
  input logic        lk_valid,
  input logic [31:0] lk_addr,
  input logic        lk_read,
  input logic        fl_valid,
  input logic        rsp_valid,
  input logic        rsp_hit,
  input logic [31:0] rsp_addr,
  input logic        rsp_berr,
  input logic        rsp_inval,
  input logic        rsp_wprot,
  input logic        rsp_mod
);
  // R13
  held_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid || fl_valid) |=> !rsp_valid);

  // R2
  resp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !ins_valid && !fl_valid) |=> rsp_valid);

  // R7
  miss_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |->
      (rsp_inval && !rsp_berr && !rsp_wprot && !rsp_mod && rsp_addr == 32'h0));

  // R5
  berr_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_berr) |-> (rsp_inval && rsp_hit));

  // R6
  write_hit_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit && !$past(lk_read)) |-> rsp_mod);

  // R3
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (rsp_addr[7:0] == $past(lk_addr[7:0])));
endmodule

bind fc_xlate_cache fcx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .lk_valid(lk_valid),
  .lk_addr(lk_addr), .lk_read(lk_read), .fl_valid(fl_valid),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_addr(rsp_addr),
  .rsp_berr(rsp_berr), .rsp_inval(rsp_inval), .rsp_wprot(rsp_wprot),
  .rsp_mod(rsp_mod));

// File: tb/tb_fc_xlate_cache.sv
module tb_fc_xlate_cache;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  cfg_page_bits;
  logic        ins_valid, ins_read, ins_berr, ins_inval, ins_supv, ins_wprot;
  logic [31:0] ins_laddr, ins_paddr;
  logic [2:0]  ins_fc;
  logic        lk_valid, lk_read;
  logic [31:0] lk_addr;
  logic [2:0]  lk_fc;
  logic        fl_valid;
  logic [1:0]  fl_mode;
  logic [2:0]  fl_fc, fl_mask;
  logic [31:0] fl_addr;
  logic        rsp_valid, rsp_hit, rsp_berr, rsp_inval, rsp_wprot, rsp_mod;
  logic [31:0] rsp_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fc_xlate_cache dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ins(input logic [31:0] la, input logic [31:0] pa, input logic [2:0] fc,
                     input logic rd, input logic [3:0] st);
    @(negedge clk);
    ins_valid = 1'b1; ins_laddr = la; ins_paddr = pa; ins_fc = fc; ins_read = rd;
    {ins_berr, ins_inval, ins_supv, ins_wprot} = st;
    @(negedge clk);
    ins_valid = 1'b0;
  endtask

  task automatic lk(input logic [31:0] a, input logic [2:0] fc, input logic rd);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a; lk_fc = fc; lk_read = rd;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic fl(input logic [1:0] mode, input logic [2:0] fc, input logic [2:0] mask,
                    input logic [31:0] a);
    @(negedge clk);
    fl_valid = 1'b1; fl_mode = mode; fl_fc = fc; fl_mask = mask; fl_addr = a;
    @(negedge clk);
    fl_valid = 1'b0;
  endtask

  task automatic exp_hit(input string req, input logic [31:0] ea);
    chk(rsp_valid && rsp_hit, req, {30'h0, rsp_valid, rsp_hit}, 32'h3);
    chk(rsp_addr == ea, req, rsp_addr, ea);
  endtask

  task automatic exp_miss(input string req);
    chk(rsp_valid && !rsp_hit && rsp_inval && !rsp_berr && !rsp_wprot && !rsp_mod
        && rsp_addr == 0, req,
        {25'h0, rsp_valid, rsp_hit, rsp_inval, rsp_berr, rsp_wprot, rsp_mod, |rsp_addr},
        {25'h0, 7'b1010000});
  endtask

  task automatic t_reset;
    chk(!rsp_valid, "R1 reset rsp_valid", {31'h0, rsp_valid}, 0);
    lk(32'h0000_1000, 3'd1, 1'b1);
    exp_miss("R1 first lookup misses");
    exp_miss("R7 miss status");
  endtask

  task automatic t_basic;
    ins(32'h0040_2000, 32'h1234_5000, 3'd5, 1'b1, 4'h0);
    lk(32'h0040_2abc, 3'd5, 1'b1);
    exp_hit("R2 translated address", 32'h1234_5abc);
    chk(!rsp_berr && !rsp_inval && !rsp_wprot && !rsp_mod, "R2 clean status",
        {28'h0, rsp_berr, rsp_inval, rsp_wprot, rsp_mod}, 0);
    lk(32'h0040_2abc, 3'd1, 1'b1);
    exp_miss("R4 other function code misses");
  endtask

  task automatic t_page;
    fl(2'd0, 3'd0, 3'd0, 32'h0);
    cfg_page_bits = 4'd10;
    ins(32'h0000_0c00, 32'h00ab_c400, 3'd1, 1'b1, 4'h0);
    lk(32'h0000_0fff, 3'd1, 1'b1);
    exp_hit("R3 ps=10 offset", 32'h00ab_c7ff);
    lk(32'h0000_0800, 3'd1, 1'b1);
    exp_miss("R3 ps=10 other page");
    fl(2'd0, 3'd0, 3'd0, 32'h0);
    cfg_page_bits = 4'd4;
    ins(32'h0000_1234, 32'h0000_5600, 3'd1, 1'b1, 4'h0);
    lk(32'h0000_12ab, 3'd1, 1'b1);
    exp_hit("R3 ps below 8 acts as 8", 32'h0000_56ab);
    fl(2'd0, 3'd0, 3'd0, 32'h0);
    cfg_page_bits = 4'd12;
  endtask

  task automatic t_status;
    ins(32'h0010_0000, 32'h0020_0000, 3'd1, 1'b1, 4'b0100); // invalid
    lk(32'h0010_0004, 3'd1, 1'b1);
    chk(rsp_hit && rsp_berr && rsp_inval, "R5 invalid -> bus error",
        {29'h0, rsp_hit, rsp_berr, rsp_inval}, 3'b111);
    ins(32'h0011_0000, 32'h0021_0000, 3'd1, 1'b1, 4'b0010); // supervisor
    lk(32'h0011_0000, 3'd1, 1'b1);
    chk(rsp_hit && rsp_berr && rsp_inval, "R5 supervisor -> bus error",
        {29'h0, rsp_hit, rsp_berr, rsp_inval}, 3'b111);
    ins(32'h0012_0000, 32'h0022_0000, 3'd1, 1'b0, 4'b0001); // write, protected
    lk(32'h0012_0010, 3'd1, 1'b1);
    chk(rsp_hit && rsp_wprot && !rsp_mod && !rsp_berr, "R5 write-protect, no modified",
        {29'h0, rsp_wprot, rsp_mod, rsp_berr}, 3'b100);
    ins(32'h0013_0000, 32'h0023_0000, 3'd1, 1'b0, 4'b0000); // write
    lk(32'h0013_0020, 3'd1, 1'b0);
    exp_hit("R5 write sets modified", 32'h0023_0020);
    chk(rsp_mod && !rsp_wprot, "R5 modified flag", {30'h0, rsp_mod, rsp_wprot}, 2'b10);
  endtask

  task automatic t_wmiss;
    ins(32'h0014_0000, 32'h0024_0000, 3'd2, 1'b1, 4'h0);
    lk(32'h0014_0000, 3'd2, 1'b0);
    exp_miss("R6 write to unmodified misses");
    lk(32'h0014_0000, 3'd2, 1'b1);
    exp_miss("R6 entry invalidated");
  endtask

  task automatic t_overwrite;
    fl(2'd0, 3'd0, 3'd0, 32'h0);
    ins(32'h0500_0000, 32'h0600_0000, 3'd1, 1'b1, 4'h0);
    ins(32'h0500_0000, 32'h0700_0000, 3'd1, 1'b1, 4'h0);
    lk(32'h0500_0abc, 3'd1, 1'b1);
    exp_hit("R8 data overwritten", 32'h0700_0abc);
    for (int n = 0; n < 15; n++)
      ins(32'h0800_0000 + (n << 12), 32'h0900_0000 + (n << 12), 3'd1, 1'b1, 4'h0);
    lk(32'h0500_0abc, 3'd1, 1'b1);
    exp_hit("R8 no second entry allocated", 32'h0700_0abc);
  endtask

  task automatic t_repl;
    fl(2'd0, 3'd0, 3'd0, 32'h0);
    for (int n = 0; n < 17; n++)
      ins(32'h0100_0000 + (n << 12), 32'h0200_0000 + (n << 12), 3'd1, 1'b1, 4'h0);
    lk(32'h0100_0000, 3'd1, 1'b1);
    exp_miss("R9 first victim entry 0");
    lk(32'h0100_1000, 3'd1, 1'b1);
    exp_hit("R9 entry 1 kept", 32'h0200_1000);
    ins(32'h0100_0000 + (17 << 12), 32'h0200_0000 + (17 << 12), 3'd1, 1'b1, 4'h0);
    lk(32'h0100_1000, 3'd1, 1'b1);
    exp_miss("R9 second victim entry 1");
    lk(32'h0100_2000, 3'd1, 1'b1);
    exp_hit("R9 entry 2 kept", 32'h0200_2000);
    // flush all: pointer back to 0
    fl(2'd0, 3'd0, 3'd0, 32'h0);
    lk(32'h0100_2000, 3'd1, 1'b1);
    exp_miss("R10 flush all clears");
    for (int n = 0; n < 17; n++)
      ins(32'h0300_0000 + (n << 12), 32'h0400_0000 + (n << 12), 3'd3, 1'b1, 4'h0);
    lk(32'h0300_0000, 3'd3, 1'b1);
    exp_miss("R10 pointer reset, victim entry 0");
    lk(32'h0300_1000, 3'd3, 1'b1);
    exp_hit("R10 entry 1 kept", 32'h0400_1000);
    lk(32'h0300_2000, 3'd3, 1'b1);
    exp_hit("R10 entry 2 kept", 32'h0400_2000);
  endtask

  task automatic t_flcode;
    fl(2'd0, 3'd0, 3'd0, 32'h0);
    ins(32'h0a00_0000, 32'h0b00_0000, 3'd1, 1'b1, 4'h0);
    ins(32'h0a00_0000, 32'h0b01_0000, 3'd2, 1'b1, 4'h0);
    ins(32'h0a00_0000, 32'h0b02_0000, 3'd5, 1'b1, 4'h0);
    ins(32'h0a00_0000, 32'h0b03_0000, 3'd6, 1'b1, 4'h0);
    fl(2'd1, 3'd4, 3'd4, 32'h0);
    lk(32'h0a00_0000, 3'd1, 1'b1); exp_hit("R11 fc1 kept", 32'h0b00_0000);
    lk(32'h0a00_0000, 3'd2, 1'b1); exp_hit("R11 fc2 kept", 32'h0b01_0000);
    lk(32'h0a00_0000, 3'd5, 1'b1); exp_miss("R11 fc5 flushed");
    lk(32'h0a00_0000, 3'd6, 1'b1); exp_miss("R11 fc6 flushed");
  endtask

  task automatic t_flea;
    fl(2'd0, 3'd0, 3'd0, 32'h0);
    ins(32'h0c00_0000, 32'h0d00_0000, 3'd1, 1'b1, 4'h0);
    ins(32'h0c00_1000, 32'h0d00_1000, 3'd1, 1'b1, 4'h0);
    ins(32'h0c00_0000, 32'h0d00_2000, 3'd5, 1'b1, 4'h0);
    fl(2'd3, 3'd1, 3'd7, 32'h0c00_0000);
    lk(32'h0c00_0000, 3'd1, 1'b1); exp_hit("R12 mode 3 no effect", 32'h0d00_0000);
    fl(2'd2, 3'd1, 3'd7, 32'h0c00_0123);
    lk(32'h0c00_0000, 3'd1, 1'b1); exp_miss("R12 matching page flushed");
    lk(32'h0c00_1000, 3'd1, 1'b1); exp_hit("R12 other page kept", 32'h0d00_1000);
    lk(32'h0c00_0000, 3'd5, 1'b1); exp_hit("R12 other code kept", 32'h0d00_2000);
  endtask

  task automatic t_prio;
    fl(2'd0, 3'd0, 3'd0, 32'h0);
    ins(32'h0e00_0000, 32'h0f00_0000, 3'd1, 1'b1, 4'h0);
    // insert and lookup together
    @(negedge clk);
    ins_valid = 1'b1; ins_laddr = 32'h0e10_0000; ins_paddr = 32'h0f10_0000;
    ins_fc = 3'd1; ins_read = 1'b1; {ins_berr, ins_inval, ins_supv, ins_wprot} = 4'h0;
    lk_valid = 1'b1; lk_addr = 32'h0e00_0000; lk_fc = 3'd1; lk_read = 1'b1;
    @(negedge clk);
    ins_valid = 1'b0; lk_valid = 1'b0;
    chk(!rsp_valid, "R13 lookup dropped under insert", {31'h0, rsp_valid}, 0);
    lk(32'h0e10_0040, 3'd1, 1'b1);
    exp_hit("R13 insert took effect", 32'h0f10_0040);
    // write lookup to unmodified entry held off by insert: entry must survive
    @(negedge clk);
    ins_valid = 1'b1; ins_laddr = 32'h0e20_0000; ins_paddr = 32'h0f20_0000;
    lk_valid = 1'b1; lk_addr = 32'h0e00_0000; lk_read = 1'b0;
    @(negedge clk);
    ins_valid = 1'b0; lk_valid = 1'b0;
    lk(32'h0e00_0000, 3'd1, 1'b1);
    exp_hit("R13 dropped lookup changed no entry", 32'h0f00_0000);
    // flush with insert
    @(negedge clk);
    fl_valid = 1'b1; fl_mode = 2'd0;
    ins_valid = 1'b1; ins_laddr = 32'h0e30_0000; ins_paddr = 32'h0f30_0000;
    @(negedge clk);
    fl_valid = 1'b0; ins_valid = 1'b0;
    lk(32'h0e30_0000, 3'd1, 1'b1);
    exp_miss("R13 insert dropped under flush");
    lk(32'h0e00_0000, 3'd1, 1'b1);
    exp_miss("R13 flush applied");
    // flush with lookup
    @(negedge clk);
    fl_valid = 1'b1; fl_mode = 2'd3;
    lk_valid = 1'b1; lk_addr = 32'h0e00_0000; lk_read = 1'b1;
    @(negedge clk);
    fl_valid = 1'b0; lk_valid = 1'b0;
    chk(!rsp_valid, "R13 lookup dropped under flush", {31'h0, rsp_valid}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_page_bits = 4'd12;
    ins_valid = 0; ins_laddr = 0; ins_paddr = 0; ins_fc = 0; ins_read = 1;
    ins_berr = 0; ins_inval = 0; ins_supv = 0; ins_wprot = 0;
    lk_valid = 0; lk_addr = 0; lk_fc = 0; lk_read = 1;
    fl_valid = 0; fl_mode = 0; fl_fc = 0; fl_mask = 0; fl_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_page;
    t_status;
    t_wmiss;
    t_overwrite;
    t_repl;
    t_flcode;
    t_flea;
    t_prio;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule